// File: doc/BRIEF.md
# Address-Triggered DMA Bus Grabber

This block sits beside an 8-bit CPU whose bus can be frozen through an active-low halt input and whose bus status is reported on two outputs (here `cpu_ba` and `cpu_bs`). Software loads a source address, a destination address and a byte count, then touches a trigger address. The block answers by pulling `halt_n` low. It waits until both status lines read high, copies the bytes by driving the address, data and read/write lines itself, and then hands the bus back.

The CPU acts on a halt request only if the request is present early in the second-to-last cycle of an instruction. So the CPU always finishes at least one more instruction after the trigger access, and software places a NOP (opcode 0x12) after the trigger. In guard mode the block relies on this. The trigger access only arms a flag, and the copy starts only if the very next bus cycle fetches that NOP. Any other opcode disarms the flag. While the CPU is halted its address lines show 0xFFFF. For that reason bus ownership is judged from the status lines alone.

The sequencer states are: `ST_IDLE` (waiting for a start), `ST_GRANT_WAIT` (halt asserted, waiting for both status lines high), `ST_READ` (drive source address, read), `ST_WRITE` (drive destination address and data, write), `ST_RELEASE` (all drivers off, halt still asserted) and `ST_DONE` (halt released, done pulse). The transitions are:
- `ST_IDLE` to `ST_GRANT_WAIT` on a start.
- `ST_GRANT_WAIT` to `ST_READ` on grant with a non-zero count, or to `ST_RELEASE` on grant with a zero count.
- `ST_READ` always to `ST_WRITE`.
- `ST_WRITE` to `ST_READ` while bytes remain, or to `ST_RELEASE` after the last byte.
- `ST_RELEASE` to `ST_DONE`.
- `ST_DONE` to `ST_IDLE`.

Top module: `dma_bus_grabber`

## Requirements
- R1: With `guard_en`=0, a bus cycle (`bus_cycle`=1) at address 0xFF61 while idle drives `halt_n` low from the next clock on.
- R2: After `halt_n` falls, none of `addr_oe`, `data_oe`, `rw_oe` rises until a clock edge has sampled `cpu_ba`=1 and `cpu_bs`=1. The address lines play no part in this decision, and the drivers are only ever on while `halt_n`=0.
- R3: Each byte takes two clocks. The read clock drives `dma_addr`=source with `dma_rw`=1 and `addr_oe`=`rw_oe`=1. The write clock drives `dma_addr`=destination, `dma_dout`=the byte sampled on `bus_din` at the end of the read clock, `dma_rw`=0 and all three enables high. Both addresses then step by one.
- R4: A byte count of 0 produces no read or write clock. The block goes from grant straight to the release sequence.
- R5: After the last byte there is one clock with every enable low and `halt_n` still low. On the next clock `halt_n` returns high and `done` is 1 for exactly that one clock.
- R6: With `guard_en`=1, a trigger access does not drive `halt_n` low. The next bus cycle starts the transfer only if `bus_din`=0x12. Any other value clears the arm flag, and `halt_n` stays high.
- R7: Config writes (`cfg_we`=1) load the source address for `cfg_sel`=0, the destination for 1 and the count for 2. They are ignored while the block is not idle.
- R8: `irq_out_n` follows `irq_in_n` while `halt_n`=1 and is held high while `halt_n`=0, so the block's halt request outranks interrupts.
- R9: A synchronous reset returns the block to idle with `halt_n`=1, all enables low and `done`=0, and clears the arm flag.
- R10: Trigger accesses seen while a transfer is in progress do not start a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per edge |
| rst | input | 1 | Synchronous reset, active high |
| guard_en | input | 1 | Require a NOP fetch after the trigger |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count |
| cfg_wdata | input | 16 | Config write data |
| bus_cycle | input | 1 | CPU bus cycle valid |
| bus_addr | input | 16 | CPU address |
| bus_din | input | 8 | Data bus as seen by the block |
| cpu_ba | input | 1 | CPU bus status line A |
| cpu_bs | input | 1 | CPU bus status line S |
| irq_in_n | input | 1 | Interrupt request from the system, active low |
| halt_n | output | 1 | Halt request to the CPU, active low |
| irq_out_n | output | 1 | Interrupt request passed to the CPU |
| dma_addr | output | 16 | Address driven during DMA |
| dma_dout | output | 8 | Data driven during DMA writes |
| dma_rw | output | 1 | 1 read, 0 write |
| addr_oe | output | 1 | Tri-state enable for the address bus |
| data_oe | output | 1 | Tri-state enable for the data bus |
| rw_oe | output | 1 | Tri-state enable for the read/write line |
| done | output | 1 | One-clock pulse when halt is released |

## Verification
The hardest situations to reach from the ports are those where the config port or the trigger decoder is exercised while a copy is in flight. There, the effect of an ignored write only shows up in a later transfer. The stimulus issues a source-register write and a trigger access during a read clock, lets the copy finish, then reloads only the count and fires again. The new read address must continue from where the incremented source register left off, and no extra halt may appear. Guard-mode arming is also cut short by a reset before the NOP cycle arrives.

// File: rtl/grab_pkg.sv
package grab_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRANT_WAIT,
        ST_READ,
        ST_WRITE,
        ST_RELEASE,
        ST_DONE
    } grab_state_t;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
endpackage

// File: rtl/grab_trigger.sv
module grab_trigger #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] TRIG_ADDR = 16'hFF61,
    parameter logic [DW-1:0] NOP_OP = 8'h12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          guard_en,
    input  logic          bus_cycle,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_din,
    output logic          start
);
    logic hit;
    logic arm_q;   // set by a guarded trigger, marks the next bus cycle as the fetch to inspect

    assign hit = enable && bus_cycle && (bus_addr == TRIG_ADDR);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            arm_q <= 1'b0;
        end else if (arm_q && bus_cycle) begin
            arm_q <= 1'b0;
        end else if (hit && guard_en) begin
            arm_q <= 1'b1;
        end
    end

    always_comb begin
        start = 1'b0;
        if (enable) begin
            if (arm_q) begin
                start = bus_cycle && (bus_din == NOP_OP);
            end else begin
                start = hit && !guard_en;
            end
        end
    end
endmodule

// File: rtl/grab_regs.sv
module grab_regs
    import grab_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_open,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             step,
    output logic [AW-1:0]    src,
    output logic [AW-1:0]    dst,
    output logic [CW-1:0]    cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            src <= '0;
            dst <= '0;
            cnt <= '0;
        end else if (step) begin
            src <= src + AW'(1);
            dst <= dst + AW'(1);
            cnt <= cnt - CW'(1);
        end else if (cfg_we && cfg_open) begin
            case (cfg_sel)
                SEL_SRC: src <= cfg_wdata[AW-1:0];
                SEL_DST: dst <= cfg_wdata[AW-1:0];
                SEL_CNT: cnt <= cfg_wdata[CW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/grab_seq.sv
module grab_seq
    import grab_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cpu_ba,
    input  logic          cpu_bs,
    input  logic          cnt_zero,
    input  logic          cnt_last,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] bus_din,
    output logic          idle,
    output logic          step,
    output logic          halt_n,
    output logic [AW-1:0] dma_addr,
    output logic [DW-1:0] dma_dout,
    output logic          dma_rw,
    output logic          addr_oe,
    output logic          data_oe,
    output logic          rw_oe,
    output logic          done
);
    grab_state_t state, state_nx;
    logic [DW-1:0] byte_q;
    logic granted;

    assign granted = cpu_ba && cpu_bs;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
        end else if (state == ST_READ) begin
            byte_q <= bus_din;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start) state_nx = ST_GRANT_WAIT;
            ST_GRANT_WAIT: if (granted) state_nx = cnt_zero ? ST_RELEASE : ST_READ;
            ST_READ:       state_nx = ST_WRITE;
            ST_WRITE:      state_nx = cnt_last ? ST_RELEASE : ST_READ;
            ST_RELEASE:    state_nx = ST_DONE;
            ST_DONE:       state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle     = 1'b0;
        step     = 1'b0;
        halt_n   = 1'b1;
        dma_addr = '0;
        dma_dout = byte_q;
        dma_rw   = 1'b1;
        addr_oe  = 1'b0;
        data_oe  = 1'b0;
        rw_oe    = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:       idle = 1'b1;
            ST_GRANT_WAIT: halt_n = 1'b0;
            ST_READ: begin
                halt_n   = 1'b0;
                dma_addr = src;
                addr_oe  = 1'b1;
                rw_oe    = 1'b1;
            end
            ST_WRITE: begin
                halt_n   = 1'b0;
                dma_addr = dst;
                dma_rw   = 1'b0;
                addr_oe  = 1'b1;
                rw_oe    = 1'b1;
                data_oe  = 1'b1;
                step     = 1'b1;
            end
            ST_RELEASE:    halt_n = 1'b0;
            ST_DONE:       done = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma_bus_grabber.sv
module dma_bus_grabber #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 16,
    parameter logic [AW-1:0] TRIG_ADDR = 16'hFF61,
    parameter logic [DW-1:0] NOP_OP = 8'h12,
    localparam int CFG_W = (AW > CW) ? AW : CW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             guard_en,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             bus_cycle,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_din,
    input  logic             cpu_ba,
    input  logic             cpu_bs,
    input  logic             irq_in_n,
    output logic             halt_n,
    output logic             irq_out_n,
    output logic [AW-1:0]    dma_addr,
    output logic [DW-1:0]    dma_dout,
    output logic             dma_rw,
    output logic             addr_oe,
    output logic             data_oe,
    output logic             rw_oe,
    output logic             done
);
    logic          idle;
    logic          start;
    logic          step;
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [CW-1:0] cnt;

    grab_trigger #(
        .AW(AW), .DW(DW), .TRIG_ADDR(TRIG_ADDR), .NOP_OP(NOP_OP)
    ) u_trig (
        .clk(clk), .rst(rst), .enable(idle), .guard_en(guard_en),
        .bus_cycle(bus_cycle), .bus_addr(bus_addr), .bus_din(bus_din),
        .start(start)
    );

    grab_regs #(.AW(AW), .CW(CW), .CFG_W(CFG_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_open(idle), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .step(step),
        .src(src), .dst(dst), .cnt(cnt)
    );

    grab_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .cpu_ba(cpu_ba), .cpu_bs(cpu_bs),
        .cnt_zero(cnt == '0), .cnt_last(cnt == CW'(1)),
        .src(src), .dst(dst), .bus_din(bus_din),
        .idle(idle), .step(step), .halt_n(halt_n),
        .dma_addr(dma_addr), .dma_dout(dma_dout), .dma_rw(dma_rw),
        .addr_oe(addr_oe), .data_oe(data_oe), .rw_oe(rw_oe), .done(done)
    );

    // own halt request outranks interrupts
    assign irq_out_n = irq_in_n | ~halt_n;
endmodule

// File: rtl/grab_checker.sv
module grab_checker (
    input logic clk,
    input logic rst,
    input logic halt_n,
    input logic cpu_ba,
    input logic cpu_bs,
    input logic addr_oe,
    input logic data_oe,
    input logic rw_oe,
    input logic dma_rw,
    input logic done
);
    assert_no_drive_before_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_oe) |-> $past(cpu_ba && cpu_bs));

    assert_drive_only_halted_R2: assert property (@(posedge clk) disable iff (rst)
        (addr_oe || data_oe || rw_oe) |-> !halt_n);

    assert_write_cycle_shape_R3: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (addr_oe && rw_oe && !dma_rw));

    assert_write_single_clock_R3: assert property (@(posedge clk) disable iff (rst)
        data_oe |=> !data_oe);

    assert_quiet_before_release_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_n) |-> (!addr_oe && !data_oe && !rw_oe && $past(!addr_oe && !data_oe && !rw_oe)));

    assert_done_marks_release_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(halt_n));

    assert_done_one_clock_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind dma_bus_grabber grab_checker u_chk (
    .clk(clk), .rst(rst), .halt_n(halt_n), .cpu_ba(cpu_ba), .cpu_bs(cpu_bs),
    .addr_oe(addr_oe), .data_oe(data_oe), .rw_oe(rw_oe), .dma_rw(dma_rw),
    .done(done)
);

// File: tb/tb_dma_bus_grabber.sv
module tb_dma_bus_grabber;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        guard_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_cycle = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_din = '0;
    logic        cpu_ba = 1'b0;
    logic        cpu_bs = 1'b0;
    logic        irq_in_n = 1'b1;
    logic        halt_n, irq_out_n, dma_rw, addr_oe, data_oe, rw_oe, done;
    logic [15:0] dma_addr;
    logic [7:0]  dma_dout;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam logic [15:0] TRIG = 16'hFF61;
    localparam logic [7:0]  NOP  = 8'h12;

    // {guard, src, dst, count, opcode after trigger}
    localparam int NV = 6;
    localparam logic [56:0] VEC [NV] = '{
        {1'b0, 16'h1000, 16'h2000, 16'd3, 8'h00},
        {1'b0, 16'h10FE, 16'h20FF, 16'd4, 8'h86},
        {1'b0, 16'h1234, 16'h4321, 16'd0, 8'h12},
        {1'b1, 16'h0800, 16'h0900, 16'd2, 8'h12},
        {1'b1, 16'h0A00, 16'h0B00, 16'd2, 8'h86},
        {1'b1, 16'hFFFF, 16'h7000, 16'd1, 8'h12}
    };

    dma_bus_grabber dut (
        .clk(clk), .rst(rst), .guard_en(guard_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_cycle(bus_cycle),
        .bus_addr(bus_addr), .bus_din(bus_din), .cpu_ba(cpu_ba), .cpu_bs(cpu_bs),
        .irq_in_n(irq_in_n), .halt_n(halt_n), .irq_out_n(irq_out_n),
        .dma_addr(dma_addr), .dma_dout(dma_dout), .dma_rw(dma_rw),
        .addr_oe(addr_oe), .data_oe(data_oe), .rw_oe(rw_oe), .done(done)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_xfer(input logic g, input logic [15:0] s, input logic [15:0] d,
                            input logic [15:0] n, input logic [7:0] op,
                            input bit prog_addr, input bit poke);
        bit go;
        go = !g || (op == NOP);
        guard_en = g;
        if (prog_addr) begin
            wr_cfg(2'd0, s);
            wr_cfg(2'd1, d);
        end
        wr_cfg(2'd2, n);
        bus_cycle = 1'b1; bus_addr = TRIG; bus_din = 8'h00;       // trigger access
        @(negedge clk);
        if (g) chk("R6 armed no halt", halt_n, 1);
        else   chk("R1 halt after trigger", halt_n, 0);
        bus_addr = 16'h0104; bus_din = op;                         // next opcode fetch
        @(negedge clk);
        bus_addr = 16'h0105; bus_din = 8'h00;
        if (!go) begin
            for (int k = 0; k < 3; k++) begin
                chk("R6 non-NOP no transfer", halt_n, 1);
                @(negedge clk);
            end
            bus_cycle = 1'b0;
            return;
        end
        chk("R6/R1 halt asserted", halt_n, 0);
        bus_cycle = 1'b0; bus_addr = 16'hFFFF; irq_in_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
            chk("R2 no drive before grant", addr_oe | data_oe | rw_oe, 0);
            chk("R8 irq masked while halting", irq_out_n, 1);
            @(negedge clk);
        end
        irq_in_n = 1'b1;
        cpu_ba = 1'b1; cpu_bs = 1'b1;
        @(negedge clk);
        for (int i = 0; i < int'(n); i++) begin
            chk("R3 read addr_oe", addr_oe & rw_oe & ~data_oe, 1);
            chk("R3 read address", dma_addr, 16'(s + 16'(i)));
            chk("R3 read rw", dma_rw, 1);
            bus_din = mem(dma_addr);
            if (poke && i == 0) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h5555;   // R7 ignored write
                bus_cycle = 1'b1; bus_addr = TRIG;                     // R10 ignored trigger
            end
            @(negedge clk);
            cfg_we = 1'b0; bus_cycle = 1'b0; bus_addr = 16'hFFFF;
            chk("R3 write enables", addr_oe & rw_oe & data_oe, 1);
            chk("R3 write address", dma_addr, 16'(d + 16'(i)));
            chk("R3 write data", dma_dout, mem(16'(s + 16'(i))));
            chk("R3 write rw", dma_rw, 0);
            @(negedge clk);
        end
        if (n == 0) chk("R4 zero count no bus cycle", addr_oe | data_oe | rw_oe, 0);
        chk("R5 quiet clock drivers off", addr_oe | data_oe | rw_oe, 0);
        chk("R5 quiet clock halt held", halt_n, 0);
        @(negedge clk);
        chk("R5 halt released", halt_n, 1);
        chk("R5 done pulse", done, 1);
        cpu_ba = 1'b0; cpu_bs = 1'b0;
        @(negedge clk);
        chk("R5 done one clock", done, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9 reset halt_n", halt_n, 1);
        chk("R9 reset enables", addr_oe | data_oe | rw_oe, 0);
        chk("R9 reset done", done, 0);
        irq_in_n = 1'b0;
        #1 chk("R8 irq passes when idle", irq_out_n, 0);
        irq_in_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_xfer(VEC[v][56], VEC[v][55:40], VEC[v][39:24], VEC[v][23:8], VEC[v][7:0], 1'b1, 1'b0);
            repeat (2) @(negedge clk);
        end

        // R7 / R10: config write and trigger during a transfer are ignored
        run_xfer(1'b0, 16'h3000, 16'h4000, 16'd2, 8'h00, 1'b1, 1'b1);
        repeat (2) begin
            chk("R10 no second transfer", halt_n, 1);
            @(negedge clk);
        end
        run_xfer(1'b0, 16'h3002, 16'h4002, 16'd1, 8'h00, 1'b0, 1'b0);   // R7 source kept incremented value
        repeat (2) @(negedge clk);

        // R9: reset clears the arm flag
        guard_en = 1'b1;
        wr_cfg(2'd2, 16'd1);
        bus_cycle = 1'b1; bus_addr = TRIG;
        @(negedge clk);
        bus_cycle = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_cycle = 1'b1; bus_addr = 16'h0200; bus_din = NOP;
        @(negedge clk);
        bus_cycle = 1'b0;
        chk("R9 arm cleared by reset", halt_n, 1);
        @(negedge clk);
        chk("R9 still idle", halt_n, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule